// File: doc/BRIEF.md
# USB Bus Reset and Chirp Detector

This block watches the decoded USB line state and decides when the host is resetting the bus. It gives a device controller a bus-reset flag, a one-cycle pulse that sends the device logic back to its Default state, a request to drive Chirp-K, and an indication of whether high speed was granted.

In full-speed mode a short stretch of SE0 is enough to raise the flag. The flag then follows the line until SE0 ends.

In high-speed mode the block first waits for a much longer SE0. It then lets the line settle and samples it once. SE0 at that sample confirms a reset, and J means the bus is going into suspend. After a confirmed reset the block requests Chirp-K for a fixed time. It then listens for the host's alternating K-J-K-J-K-J chirp. The flag is held until that pattern is recognized or until a waiting window expires. High speed is granted only when the pattern is recognized.

All time thresholds are given in nanoseconds and converted to clock cycles from a clock-frequency parameter. A test setup can therefore use scaled-down values.

Top module: `usb_rst_chirp_det`

## Requirements
- R1: `line_i` is coded as 0 = SE0, 1 = J, 2 = K and 3 = invalid, and it is sampled on every rising clock edge. During and after reset, every output is 0.
- R2: With `hs_mode_i` = 0, `bus_rst_o` goes high after the edge that samples the FS_CYC-th consecutive SE0. A run of FS_CYC-1 SE0 samples raises nothing. The flag drops after the first edge that samples any value other than SE0.
- R3: With `hs_mode_i` = 1, the short full-speed threshold has no effect. After HS_CYC consecutive SE0 samples, the block waits EL_CYC more edges and samples the line once: SE0 confirms a reset, J enters suspend, and any other value returns to idle. Neither of the last two raises any output.
- R4: `dflt_pulse_o` is high for exactly one cycle on each confirmed reset. It is high in the same cycle in which `bus_rst_o` rises.
- R5: After a high-speed reset is confirmed, `chirp_k_o` is high for exactly CHIRP_CYC cycles. It rises together with `bus_rst_o`, and `bus_rst_o` is high whenever `chirp_k_o` is high.
- R6: After Chirp-K ends, `bus_rst_o` stays high while the host chirp is awaited. It falls WAIT_CYC edges later if no chirp is recognized.
- R7: The host chirp is recognized from six alternating elements that start with K. Each element is accepted once it has been sampled for EL_CYC edges, and it may last longer. Any other sample, or a switch before the element is accepted, restarts the match. `hs_grant_o` rises on the edge after the match, together with the fall of `bus_rst_o`. It is cleared at every confirmed reset, and it stays 0 when the window expires.
- R8: When the match completes on the same edge that the waiting window expires, the match wins and `hs_grant_o` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hs_mode_i | input | 1 | 1 selects high-speed reset handling |
| line_i | input | 2 | Decoded line state (0 SE0, 1 J, 2 K, 3 invalid) |
| bus_rst_o | output | 1 | Bus-reset flag |
| chirp_k_o | output | 1 | Request to drive Chirp-K |
| hs_grant_o | output | 1 | High speed granted by the last reset |
| dflt_pulse_o | output | 1 | One-cycle return-to-Default pulse |

## Verification
The chirp matcher finishing and the waiting window expiring can land on the same edge. To provoke this, the bench times the host chirp so that its sixth element is accepted exactly WAIT_CYC-1 edges into the window. With the chosen parameters the two events then fall on the same edge. The bench expects `bus_rst_o` to fall with `hs_grant_o` set. As a control, the bench also stretches the first K by one cycle, which makes the match one edge late. In that case it expects the timeout to win and `hs_grant_o` to stay 0.

// File: rtl/usb_rcd_pkg.sv
package usb_rcd_pkg;
  typedef enum logic [1:0] {
    LS_SE0 = 2'd0,
    LS_J   = 2'd1,
    LS_K   = 2'd2,
    LS_BAD = 2'd3
  } line_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FS_RST,
    ST_DECIDE,
    ST_CHIRP,
    ST_HOST_WAIT,
    ST_SUSP
  } rcd_state_e;

  // ceil(khz * ns / 1e6)
  function automatic int unsigned ns_to_cyc(input longint unsigned khz,
                                            input longint unsigned ns);
    longint unsigned c;
    c = (khz * ns + 64'd999_999) / 64'd1_000_000;
    return c[31:0];
  endfunction
endpackage

// File: rtl/rcd_run_cnt.sv
module rcd_run_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hit_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_o <= '0;
    else if (!hit_i)       cnt_o <= '0;
    else if (cnt_o != '1)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/rcd_chirp_match.sv
module rcd_chirp_match
  import usb_rcd_pkg::*;
#(
  parameter int unsigned EL_CYC = 125,
  parameter int unsigned ELEMS  = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] line_i,
  output logic       match_o
);
  localparam int unsigned RW = $clog2(EL_CYC + 1);
  localparam int unsigned CW = $clog2(ELEMS + 1);

  logic [RW-1:0] run_q;
  logic [CW-1:0] cnt_q;
  line_e         want, prev;

  assign want    = cnt_q[0] ? LS_J : LS_K;
  assign prev    = cnt_q[0] ? LS_K : LS_J;
  assign match_o = (cnt_q == CW'(ELEMS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      cnt_q <= '0;
    end else if (!en_i) begin
      run_q <= '0;
      cnt_q <= '0;
    end else if (!match_o) begin
      if (line_i == want) begin
        if (run_q == RW'(EL_CYC - 1)) begin
          run_q <= '0;
          cnt_q <= cnt_q + 1'b1;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else if (cnt_q != '0 && line_i == prev && run_q == '0) begin
        run_q <= '0; // tail of the element already accepted
      end else begin
        cnt_q <= '0;
        run_q <= (line_i == LS_K) ? RW'(1) : '0;
      end
    end
  end
endmodule

// File: rtl/usb_rst_chirp_det.sv
module usb_rst_chirp_det
  import usb_rcd_pkg::*;
#(
  parameter int unsigned CLK_KHZ      = 50_000,
  parameter int unsigned FS_SE0_NS    = 2_500,
  parameter int unsigned HS_SE0_NS    = 3_000_000,
  parameter int unsigned CHIRP_NS     = 1_500_000,
  parameter int unsigned HOST_WAIT_NS = 2_000_000,
  parameter int unsigned CHIRP_EL_NS  = 2_500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hs_mode_i,
  input  logic [1:0] line_i,
  output logic       bus_rst_o,
  output logic       chirp_k_o,
  output logic       hs_grant_o,
  output logic       dflt_pulse_o
);
  localparam longint unsigned KHZ = longint'(CLK_KHZ);
  localparam int unsigned FS_CYC    = ns_to_cyc(KHZ, longint'(FS_SE0_NS));
  localparam int unsigned HS_CYC    = ns_to_cyc(KHZ, longint'(HS_SE0_NS));
  localparam int unsigned CHIRP_CYC = ns_to_cyc(KHZ, longint'(CHIRP_NS));
  localparam int unsigned WAIT_CYC  = ns_to_cyc(KHZ, longint'(HOST_WAIT_NS));
  localparam int unsigned EL_CYC    = ns_to_cyc(KHZ, longint'(CHIRP_EL_NS));
  localparam int unsigned SE0_MAX   = (HS_CYC > FS_CYC) ? HS_CYC : FS_CYC;
  localparam int unsigned TMR_MAX   = (CHIRP_CYC > WAIT_CYC) ? CHIRP_CYC : WAIT_CYC;
  localparam int unsigned SW = $clog2(SE0_MAX + 1);
  localparam int unsigned TW = $clog2(TMR_MAX + EL_CYC + 1);

  rcd_state_e    state_q, state_d;
  logic [SW-1:0] se0_cnt;
  logic [TW-1:0] tmr;
  logic          is_se0, se0_fs, se0_hs, match, confirm, grant_set;

  assign is_se0 = (line_i == LS_SE0);
  // qualify with the current sample so the flag follows the Nth SE0 edge
  assign se0_fs = is_se0 && (se0_cnt >= SW'(FS_CYC - 1));
  assign se0_hs = is_se0 && (se0_cnt >= SW'(HS_CYC - 1));

  rcd_run_cnt #(.W(SW)) u_se0 (
    .clk_i (clk_i), .rst_ni(rst_ni), .hit_i(is_se0), .cnt_o(se0_cnt)
  );

  rcd_run_cnt #(.W(TW)) u_tmr (
    .clk_i (clk_i), .rst_ni(rst_ni), .hit_i(state_d == state_q), .cnt_o(tmr)
  );

  rcd_chirp_match #(.EL_CYC(EL_CYC), .ELEMS(6)) u_match (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_HOST_WAIT),
    .line_i (line_i),
    .match_o(match)
  );

  always_comb begin
    state_d   = state_q;
    confirm   = 1'b0;
    grant_set = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (hs_mode_i) begin
          if (se0_hs) state_d = ST_DECIDE;
        end else if (se0_fs) begin
          state_d = ST_FS_RST;
          confirm = 1'b1;
        end
      end
      ST_FS_RST:
        if (!is_se0) state_d = ST_IDLE;
      ST_DECIDE:
        if (tmr == TW'(EL_CYC - 1)) begin
          if (is_se0) begin
            state_d = ST_CHIRP;
            confirm = 1'b1;
          end else if (line_i == LS_J) begin
            state_d = ST_SUSP;
          end else begin
            state_d = ST_IDLE;
          end
        end
      ST_CHIRP:
        if (tmr == TW'(CHIRP_CYC - 1)) state_d = ST_HOST_WAIT;
      ST_HOST_WAIT: begin
        if (match) begin
          state_d   = ST_IDLE;
          grant_set = 1'b1;
        end else if (tmr == TW'(WAIT_CYC - 1)) begin
          state_d = ST_IDLE;
        end
      end
      ST_SUSP:
        if (line_i != LS_J) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      dflt_pulse_o <= 1'b0;
      hs_grant_o   <= 1'b0;
    end else begin
      state_q      <= state_d;
      dflt_pulse_o <= confirm;
      if (confirm)        hs_grant_o <= 1'b0;
      else if (grant_set) hs_grant_o <= 1'b1;
    end
  end

  assign bus_rst_o = (state_q == ST_FS_RST) || (state_q == ST_CHIRP) ||
                     (state_q == ST_HOST_WAIT);
  assign chirp_k_o = (state_q == ST_CHIRP);
endmodule

// File: rtl/rcd_chk.sv
module rcd_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_rst_o,
  input logic chirp_k_o,
  input logic hs_grant_o,
  input logic dflt_pulse_o
);
  AST_CHIRP_UNDER_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chirp_k_o |-> bus_rst_o); // R5
  AST_RST_RISE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_rst_o) |-> dflt_pulse_o); // R4
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dflt_pulse_o |=> !dflt_pulse_o); // R4
  AST_CHIRP_END_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(chirp_k_o) |-> bus_rst_o); // R6
  AST_NO_GRANT_IN_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_o |-> !hs_grant_o); // R7
  AST_GRANT_AFTER_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_grant_o) |-> $fell(bus_rst_o)); // R7
endmodule

bind usb_rst_chirp_det rcd_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_rst_o   (bus_rst_o),
  .chirp_k_o   (chirp_k_o),
  .hs_grant_o  (hs_grant_o),
  .dflt_pulse_o(dflt_pulse_o)
);

// File: tb/usb_rst_chirp_det_bench.sv
`timescale 1ns/1ps
module usb_rst_chirp_det_bench;
  // 20 ns clock: cycles = ns / 20
  localparam int FS = 10, HS = 30, CH = 20, WT = 31, EL = 5;
  localparam logic [1:0] SE0 = 2'd0, LJ = 2'd1, LK = 2'd2, BAD = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0, hs_mode = 1'b0;
  logic [1:0] line = LJ;
  logic bus_rst, chirp_k, hs_grant, dflt;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  usb_rst_chirp_det #(
    .CLK_KHZ(50_000), .FS_SE0_NS(FS*20), .HS_SE0_NS(HS*20),
    .CHIRP_NS(CH*20), .HOST_WAIT_NS(WT*20), .CHIRP_EL_NS(EL*20)
  ) u_usb_rst_chirp_det (
    .clk_i(clk), .rst_ni(rst_n), .hs_mode_i(hs_mode), .line_i(line),
    .bus_rst_o(bus_rst), .chirp_k_o(chirp_k), .hs_grant_o(hs_grant),
    .dflt_pulse_o(dflt)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // drive one sample, return after the edge that took it
  task automatic step(input logic [1:0] ln);
    line = ln;
    @(negedge clk);
  endtask

  function automatic logic fs_expect(input int len);
    return len >= FS;
  endfunction

  task automatic hs_confirm();
    hs_mode = 1'b1;
    repeat (FS) step(SE0);
    chk("R3 fs threshold ignored", bus_rst, 1'b0);
    repeat (HS - FS) step(SE0);
    chk("R3 no flag before decision", bus_rst, 1'b0);
    repeat (EL) step(SE0);
    chk("R3 reset confirmed", bus_rst, 1'b1);
    chk("R5 chirp starts with flag", chirp_k, 1'b1);
    chk("R4 pulse on hs confirm", dflt, 1'b1);
    chk("R7 grant cleared on confirm", hs_grant, 1'b0);
    begin
      int n = 1;
      while (1) begin
        step(SE0);
        if (!chirp_k) break;
        n++;
      end
      checks++;
      if (n != CH) begin
        fails++;
        $display("FAIL R5 chirp length actual=%0d expected=%0d", n, CH);
      end
    end
    chk("R6 flag held after chirp", bus_rst, 1'b1);
  endtask

  task automatic host_el(input logic [1:0] s, input int n);
    repeat (n) step(s);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset flag", bus_rst, 1'b0);
    chk("R1 reset chirp", chirp_k, 1'b0);
    chk("R1 reset grant", hs_grant, 1'b0);
    chk("R1 reset pulse", dflt, 1'b0);
    rst_n = 1'b1;
    repeat (2) step(LJ);

    // full speed boundaries
    repeat (FS - 1) step(SE0);
    chk("R2 short SE0 no flag", bus_rst, 1'b0);
    step(LJ);
    chk("R2 short SE0 still none", bus_rst, 1'b0);
    repeat (FS) step(SE0);
    chk("R2 flag at threshold", bus_rst, 1'b1);
    chk("R4 pulse on fs confirm", dflt, 1'b1);
    step(SE0);
    chk("R4 pulse single cycle", dflt, 1'b0);
    chk("R2 flag held in SE0", bus_rst, 1'b1);
    step(LK);
    chk("R2 flag drops on K", bus_rst, 1'b0);
    repeat (2) step(LJ);

    // high speed: match lands on the timeout edge
    hs_confirm();
    for (int i = 0; i < 6; i++) host_el(i[0] ? LJ : LK, EL);
    chk("R6 flag held before match", bus_rst, 1'b1);
    step(LJ);
    chk("R8 coincident match wins flag", bus_rst, 1'b0);
    chk("R8 coincident match grants", hs_grant, 1'b1);
    repeat (3) step(LJ);
    chk("R7 grant persists", hs_grant, 1'b1);

    // first K one cycle long: match late, timeout wins
    hs_confirm();
    host_el(LK, EL + 1);
    for (int i = 1; i < 6; i++) host_el(i[0] ? LJ : LK, EL);
    chk("R7 late match flag dropped", bus_rst, 1'b0);
    chk("R7 late match no grant", hs_grant, 1'b0);
    step(LJ);

    // short J element restarts the matcher
    hs_confirm();
    host_el(LK, EL); host_el(LJ, 2);
    host_el(LK, EL); host_el(LJ, EL); host_el(LK, EL); host_el(LJ, EL);
    host_el(LK, EL - 1);
    chk("R7 short element no grant", hs_grant, 1'b0);
    chk("R6 window expired", bus_rst, 1'b0);
    step(LJ);

    // no chirp at all
    hs_confirm();
    repeat (WT - 1) step(SE0);
    chk("R6 flag until window end", bus_rst, 1'b1);
    step(SE0);
    chk("R6 timeout drops flag", bus_rst, 1'b0);
    chk("R7 timeout no grant", hs_grant, 1'b0);
    step(LJ);

    // suspend decision and other-state decision
    repeat (HS) step(SE0);
    repeat (EL) step(LJ);
    chk("R3 suspend no flag", bus_rst, 1'b0);
    chk("R3 suspend no chirp", chirp_k, 1'b0);
    chk("R3 suspend no pulse", dflt, 1'b0);
    repeat (5) step(LJ);
    chk("R3 suspend stays quiet", bus_rst, 1'b0);
    step(LK);
    repeat (HS) step(SE0);
    repeat (EL) step(LK);
    chk("R3 K at decision no flag", bus_rst, 1'b0);
    chk("R3 K at decision no pulse", dflt, 1'b0);
    step(LJ);

    // random full-speed bursts
    hs_mode = 1'b0;
    void'($urandom(32'd1234));
    for (int it = 0; it < 60; it++) begin
      int len = 1 + int'($urandom % (2 * FS));
      logic [1:0] sep = logic'($urandom % 3) ? LJ : (($urandom % 2) ? LK : BAD);
      repeat (len) step(SE0);
      chk("R2 random burst flag", bus_rst, fs_expect(len));
      if (len == FS) chk("R4 random burst pulse", dflt, 1'b1);
      step(sep);
      chk("R2 random burst release", bus_rst, 1'b0);
      repeat (1 + int'($urandom % 3)) step(LJ);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100_000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule